// File: doc/BRIEF.md
# Protected FSM State Register

This block holds the current state of a finite state machine in redundant form. Only the state storage is protected. The next-state logic and the outputs of the surrounding machine stay plain, and the designer hardens any of them separately if needed. On a write, the plain next-state code passes through an encoder before it is registered. On a read, the stored word passes through a correcting decoder, so the next-state logic only ever sees a corrected code.

A parameter picks one of two encodings:

- **Triplication:** three copies of the code, each held in its own register instance. The read is a bitwise majority of the three copies.
- **Hamming:** one data word plus single-error-correcting check bits.

The stored word is scrubbed. On every cycle without a write, the corrected code is re-encoded and written back. An upset is therefore removed after one cycle and cannot pair with a later one. A flag marks every cycle in which the stored word was found damaged.

An upset input XORs a mask into the stored bits at the clock edge. It is used for fault injection and is tied to zero in normal use.

Top module: `fsm_state_guard`

## Requirements
- R1: While `rst_ni` is low, every stored bit is cleared asynchronously. Zero is the protected form of state code 0 in both modes. After reset, `rd_state_o` is 0 and `err_o` is 0.
- R2: When `we_i` is high at a clock edge and `upset_i` has at most one bit set, `rd_state_o` equals the written `wr_state_i` in the following cycle.
- R3: When `we_i` is low at a clock edge and `upset_i` has at most one bit set, `rd_state_o` keeps its value.
- R4: In triplication mode, `upset_i` is 3*STATE_W bits wide. Bit i of copy c sits at position c*STATE_W+i. Flipping any single stored bit still reads back the correct state.
- R5: In Hamming mode, `upset_i` is STATE_W+P bits wide, where P is the smallest count with 2^P >= STATE_W+P+1. For STATE_W=4 that gives 7 bits. Flipping any single stored bit still reads back the correct state.
- R6: `err_o` is high in exactly the cycle after an edge at which `upset_i` was non-zero. It is low in every other cycle.
- R7: A scrub write-back on each cycle without a write clears a single upset. Two single upsets at different positions on consecutive edges are both corrected.
- R8: In triplication mode, upsets at different bit positions in different copies at the same edge are corrected.
- R9: An upset arriving at the same edge as a write still reads back the newly written state.
- R10: A four-state sequencer that feeds back the read port through the write port steps through the codes 0, 3, 5, 9 and then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write the new state this cycle |
| wr_state_i | input | STATE_W | Plain next-state code |
| upset_i | input | STORE_W | Fault-injection mask XORed into the stored bits at the edge |
| rd_state_o | output | STATE_W | Corrected current-state code |
| err_o | output | 1 | Stored word was found damaged this cycle |

## Verification
The bench builds two instances side by side, both with STATE_W=4: one in triplication mode (12 stored bits) and one in Hamming mode (7 stored bits). This width covers every one of the 16 codes. It also puts every stored position, data bits and check bits alike, within reach of a single-bit upset under each written code. Consecutive upsets show whether scrubbing works, because a register without write-back would decode them wrongly.

// File: rtl/fsm_guard_pkg.sv
package fsm_guard_pkg;

  typedef enum logic {GUARD_TMR = 1'b0, GUARD_HAM = 1'b1} guard_mode_e;

  // number of single-error-correcting check bits for w data bits
  function automatic int ham_checks(input int w);
    int p;
    p = 0;
    while ((1 << p) < (w + p + 1)) p++;
    return p;
  endfunction

  function automatic int store_width(input guard_mode_e m, input int w);
    return (m == GUARD_TMR) ? 3 * w : w + ham_checks(w);
  endfunction

endpackage

// File: rtl/guard_store_reg.sv
module guard_store_reg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] upset_i,
  output logic [W-1:0] q_o
);
  // one separate register per protected word; never shared between copies
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i ^ upset_i;
  end
endmodule

// File: rtl/guard_tmr_codec.sv
module guard_tmr_codec #(
  parameter int W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   plain_i,
  output logic [3*W-1:0] code_o,
  input  logic [3*W-1:0] code_i,
  output logic [W-1:0]   plain_o,
  output logic           err_o
);
  logic [W-1:0] copy_a, copy_b, copy_c;

  assign code_o = {plain_i, plain_i, plain_i};
  assign copy_a = code_i[0 +: W];
  assign copy_b = code_i[W +: W];
  assign copy_c = code_i[2*W +: W];
  assign plain_o = (copy_a & copy_b) | (copy_a & copy_c) | (copy_b & copy_c);
  assign err_o   = (copy_a != copy_b) || (copy_a != copy_c);

  // two agreeing copies always win the vote
  p_pair_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_b == copy_c) |-> (plain_o == copy_b));
endmodule

// File: rtl/guard_ham_codec.sv
module guard_ham_codec
  import fsm_guard_pkg::*;
#(
  parameter int W = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [W-1:0]                 plain_i,
  output logic [W+ham_checks(W)-1:0]   code_o,
  input  logic [W+ham_checks(W)-1:0]   code_i,
  output logic [W-1:0]                 plain_o,
  output logic                         err_o
);
  localparam int P = ham_checks(W);
  localparam int N = W + P;

  // codeword position pos (1..N) lives at bit pos-1; powers of two carry checks
  function automatic logic [N-1:0] ham_enc(input logic [W-1:0] d);
    logic [N-1:0] c;
    logic par;
    int j;
    c = '0;
    j = 0;
    for (int pos = 1; pos <= N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        c[pos-1] = d[j];
        j++;
      end
    end
    for (int k = 0; k < P; k++) begin
      par = 1'b0;
      for (int pos = 1; pos <= N; pos++)
        if ((((pos >> k) & 1) == 1) && (pos != (1 << k))) par = par ^ c[pos-1];
      c[(1 << k) - 1] = par;
    end
    return c;
  endfunction

  function automatic logic [P-1:0] ham_syn(input logic [N-1:0] c);
    logic [P-1:0] s;
    s = '0;
    for (int k = 0; k < P; k++)
      for (int pos = 1; pos <= N; pos++)
        if (((pos >> k) & 1) == 1) s[k] = s[k] ^ c[pos-1];
    return s;
  endfunction

  function automatic logic [W-1:0] ham_dec(input logic [N-1:0] c);
    logic [N-1:0] fixed;
    logic [P-1:0] s;
    logic [W-1:0] d;
    int j;
    fixed = c;
    s = ham_syn(c);
    if ((s != '0) && (int'(s) <= N)) fixed[int'(s) - 1] = ~fixed[int'(s) - 1];
    d = '0;
    j = 0;
    for (int pos = 1; pos <= N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        d[j] = fixed[pos-1];
        j++;
      end
    end
    return d;
  endfunction

  logic [P-1:0] syndrome;

  assign code_o   = ham_enc(plain_i);
  assign syndrome = ham_syn(code_i);
  assign plain_o  = ham_dec(code_i);
  assign err_o    = (syndrome != '0);

  // a freshly encoded word decodes back to itself
  p_roundtrip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ham_dec(code_o) == plain_i);
endmodule

// File: rtl/fsm_state_guard.sv
module fsm_state_guard
  import fsm_guard_pkg::*;
#(
  parameter int          STATE_W = 4,
  parameter guard_mode_e MODE    = GUARD_TMR
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   we_i,
  input  logic [STATE_W-1:0]                     wr_state_i,
  input  logic [store_width(MODE, STATE_W)-1:0]  upset_i,
  output logic [STATE_W-1:0]                     rd_state_o,
  output logic                                   err_o
);
  localparam int STORE_W = store_width(MODE, STATE_W);

  logic [STATE_W-1:0] plain_next;   // written code or scrub value
  logic [STORE_W-1:0] code_next;    // protected form of plain_next
  logic [STORE_W-1:0] code_q;       // stored protected word

  assign plain_next = we_i ? wr_state_i : rd_state_o;

  if (MODE == GUARD_TMR) begin : g_tmr
    for (genvar c = 0; c < 3; c++) begin : g_copy
      guard_store_reg #(.W(STATE_W)) i_reg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .d_i     (code_next[c*STATE_W +: STATE_W]),
        .upset_i (upset_i[c*STATE_W +: STATE_W]),
        .q_o     (code_q[c*STATE_W +: STATE_W])
      );
    end
    guard_tmr_codec #(.W(STATE_W)) i_codec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .plain_i (plain_next),
      .code_o  (code_next),
      .code_i  (code_q),
      .plain_o (rd_state_o),
      .err_o   (err_o)
    );
  end else begin : g_ham
    guard_store_reg #(.W(STORE_W)) i_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .d_i     (code_next),
      .upset_i (upset_i),
      .q_o     (code_q)
    );
    guard_ham_codec #(.W(STATE_W)) i_codec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .plain_i (plain_next),
      .code_o  (code_next),
      .code_i  (code_q),
      .plain_o (rd_state_o),
      .err_o   (err_o)
    );
  end

  p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ($countones(upset_i) <= 1)) |=> (rd_state_o == $past(wr_state_i)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && ($countones(upset_i) <= 1)) |=> $stable(rd_state_o));

  // with no upset at the edge, the scrubbed word is clean afterwards
  p_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upset_i == '0) |=> !err_o);
endmodule

// File: tb/test_fsm_state_guard.sv
`timescale 1ns/1ps
module test_fsm_state_guard;
  import fsm_guard_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  wr = '0;
  logic [11:0] up_t = '0;
  logic [6:0]  up_h = '0;
  logic [3:0]  rd_t, rd_h;
  logic        err_t, err_h;

  int total = 0;
  int bad = 0;
  int exp_state = 0;
  bit exp_et = 1'b0;
  bit exp_eh = 1'b0;

  always #2 clk = ~clk;

  fsm_state_guard #(.STATE_W(4), .MODE(GUARD_TMR)) i_fsm_state_guard (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .wr_state_i(wr),
    .upset_i(up_t), .rd_state_o(rd_t), .err_o(err_t));

  fsm_state_guard #(.STATE_W(4), .MODE(GUARD_HAM)) i_fsm_state_guard_ham (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .wr_state_i(wr),
    .upset_i(up_h), .rd_state_o(rd_h), .err_o(err_h));

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    check(req, "tmr state", int'(rd_t), exp_state);
    check(req, "ham state", int'(rd_h), exp_state);
    check(req, "tmr flag", int'(err_t), int'(exp_et));
    check(req, "ham flag", int'(err_h), int'(exp_eh));
  endtask

  // one clock: drive at the falling edge, update the model at the rising edge
  task automatic step(input bit w, input int nxt, input int mt, input int mh, input string req);
    we   = w;
    wr   = nxt[3:0];
    up_t = mt[11:0];
    up_h = mh[6:0];
    @(posedge clk);
    if (w) exp_state = nxt & 15;
    exp_et = (mt != 0);
    exp_eh = (mh != 0);
    @(negedge clk);
    compare_all(req);
  endtask

  function automatic int seq_next(input int s);
    case (s)
      0: return 3;
      3: return 5;
      5: return 9;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;

    // R10: demo sequencer fed from the read port
    for (int i = 0; i < 8; i++) step(1'b1, seq_next(int'(rd_t)), 0, 0, "R10");
    check("R10", "back at idle", int'(rd_t), 0);

    // R2: every code written
    for (int v = 0; v < 16; v++) step(1'b1, v, 0, 0, "R2");

    // R3: hold without write
    for (int i = 0; i < 3; i++) step(1'b0, 9, 0, 0, "R3");

    // R4 R5 R6: every single stored bit under every code, then scrub check
    for (int v = 0; v < 16; v++) begin
      step(1'b1, v, 0, 0, "R2");
      for (int b = 0; b < 12; b++) begin
        step(1'b0, 0, 1 << b, (b < 7) ? (1 << b) : 0, "R4 R5 R6");
        step(1'b0, 0, 0, 0, "R6");
      end
    end

    // R7: consecutive upsets only survive with write-back
    step(1'b1, 6, 0, 0, "R2");
    for (int b = 0; b < 4; b++) begin
      step(1'b0, 0, 1 << b, 1 << b, "R7");
      step(1'b0, 0, 1 << (b + 4), 1 << ((b + 3) % 7), "R7");
      step(1'b0, 0, 0, 0, "R7");
    end

    // R8: different bits in all three copies at once
    step(1'b1, 10, 0, 0, "R2");
    step(1'b0, 0, (1 << 0) | (1 << 5) | (1 << 10), 0, "R8");
    step(1'b0, 0, 0, 0, "R8");
    step(1'b0, 0, (1 << 3) | (1 << 6), 0, "R8");
    step(1'b0, 0, 0, 0, "R8");

    // R9: upset together with a write
    for (int b = 0; b < 7; b++) begin
      step(1'b1, (b * 5 + 1) & 15, 1 << (b + 4), 1 << b, "R9");
      step(1'b0, 0, 0, 0, "R9");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule